// File: doc/BRIEF.md
# Multi-Channel Duty-Cycle Blink Generator

This block drives up to twenty LED-style outputs. Each output blinks with its own period and on-time. A built-in prescaler divides the system clock down to a 10 ms tick. Every active channel keeps a phase counter that steps once per tick and wraps at its period. The channel is on while that counter sits below period × duty / 100, with the product rounded down. The block presents a value vector and a drive-enable vector to the GPIO data path. The drive-enable vector marks the pins this engine owns.

Software or a sequencer sends requests on a single valid/ready configuration channel. A request carries a channel mask and one of two payloads:
- a period in ticks with a duty percentage, or
- a stop flag.

A period of zero is treated as a stop. Only pins that the `pin_is_out` input marks as outputs may be touched. A request whose mask reaches any other pin is consumed and then dropped whole. `cfg_ready` is the only back-pressure. It is low during reset and from the first clock after reset it stays high, so every request is taken in the cycle it is offered. The requester must hold its fields stable only while `cfg_valid` is high and `cfg_ready` is low.

Top module: `blink_engine`

## Requirements
- R1: `tick_o` is a one-cycle pulse repeating every CLK_HZ/TICK_HZ clock cycles.
- R2: On each tick, an active channel (period nonzero) adds one to its counter, and the counter returns to 0 when the incremented value reaches or passes the period. The output pattern therefore repeats every `period` ticks.
- R3: An active channel's `drv_val` bit is 1 exactly while its counter is below floor(period × duty / 100), and 0 otherwise.
- R4: A duty above 100 acts as 100, so the channel's `drv_val` bit is held at 1.
- R5: An accepted configuration with a nonzero period sets the masked channels' counters to 0 and loads the new period and duty. The outputs reflect counter 0 from the next cycle.
- R6: An accepted stop request (`cfg_stop`=1, or `cfg_period`=0) clears counter, period and duty on the masked channels. Their `drv_val` bits go to 0 and remain 0 across later ticks.
- R7: A request with any `cfg_mask` bit set where `pin_is_out` is 0 changes no channel: `drv_mask` and every channel's blink pattern continue as before.
- R8: After reset, `drv_val` and `drv_mask` are all 0. A `drv_mask` bit rises on the first accepted request naming that channel and never falls. A `drv_val` bit is never 1 where `drv_mask` is 0.
- R9: `cfg_ready` is 1 from the first clock after reset. When a request is accepted in a cycle where the tick also arrives, the configured channels load (counter 0) and the other active channels advance normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_is_out | input | N | 1 = pin is configured as an output and may blink |
| cfg_valid | input | 1 | Configuration request present |
| cfg_ready | output | 1 | Request is accepted when valid and ready are both high |
| cfg_mask | input | N | Channels addressed by the request |
| cfg_stop | input | 1 | 1 = stop the masked channels |
| cfg_period | input | PW | Period in ticks (0 = stop) |
| cfg_duty | input | DW | On-time in percent (values above 100 act as 100) |
| tick_o | output | 1 | Tick pulse seen by the channels |
| drv_val | output | N | Output level per channel |
| drv_mask | output | N | Channels whose level is driven by this engine |

## Verification
Two functions can fall in the same clock cycle: an accepted configuration or stop, and the arrival of a tick. In that cycle the configured channels must load or clear, and every other active channel must still advance.

The bench provokes this on purpose. It waits until `tick_o` is visible just before an edge and offers a request in that cycle. The random phase also produces such collisions many times over.

Each collision is judged the same way as every other cycle. A bench-side model applies the load-before-advance rule per channel. The model's level and ownership vectors are then compared to `drv_val` and `drv_mask` at the next falling edge.

// File: rtl/blink_pkg.sv
package blink_pkg;
  localparam int unsigned PCT_FULL = 100;

  typedef enum logic [1:0] {
    CH_HOLD = 2'd0,
    CH_LOAD = 2'd1,
    CH_CLR  = 2'd2
  } ch_op_e;
endpackage

// File: rtl/blink_tick.sv
module blink_tick #(
  parameter int unsigned DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/blink_thresh.sv
module blink_thresh
  import blink_pkg::*;
#(
  parameter int unsigned PW = 16,
  parameter int unsigned DW = 8
) (
  input  logic [PW-1:0] period,
  input  logic [DW-1:0] duty,
  output logic [PW-1:0] thr
);
  localparam int unsigned XW = PW + ((DW > 7) ? DW : 7);

  logic [XW-1:0] duty_c;
  logic [XW-1:0] prod;

  always_comb begin
    duty_c = XW'(duty);
    if (duty_c > XW'(PCT_FULL)) duty_c = XW'(PCT_FULL);
    prod = XW'(period) * duty_c;
    thr  = PW'(prod / XW'(PCT_FULL));
  end
endmodule

// File: rtl/blink_chan.sv
module blink_chan
  import blink_pkg::*;
#(
  parameter int unsigned PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  ch_op_e        op,
  input  logic [PW-1:0] period_in,
  input  logic [PW-1:0] thr_in,
  output logic          val,
  output logic          own
);
  logic [PW-1:0] cnt_q, per_q, thr_q;
  logic [PW:0]   nxt;

  assign nxt = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
      thr_q <= '0;
      own   <= 1'b0;
    end else begin
      case (op)
        CH_CLR: begin
          cnt_q <= '0;
          per_q <= '0;
          thr_q <= '0;
          own   <= 1'b1;
        end
        CH_LOAD: begin
          cnt_q <= '0;
          per_q <= period_in;
          thr_q <= thr_in;
          own   <= 1'b1;
        end
        default: begin
          if (tick && per_q != '0) begin
            if (nxt >= {1'b0, per_q}) cnt_q <= '0;
            else                      cnt_q <= nxt[PW-1:0];
          end
        end
      endcase
    end
  end

  assign val = (per_q != '0) && (cnt_q < thr_q);
endmodule

// File: rtl/blink_engine.sv
module blink_engine
  import blink_pkg::*;
#(
  parameter int unsigned N       = 20,
  parameter int unsigned PW      = 16,
  parameter int unsigned DW      = 8,
  parameter int unsigned CLK_HZ  = 100_000_000,
  parameter int unsigned TICK_HZ = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pin_is_out,
  input  logic          cfg_valid,
  output logic          cfg_ready,
  input  logic [N-1:0]  cfg_mask,
  input  logic          cfg_stop,
  input  logic [PW-1:0] cfg_period,
  input  logic [DW-1:0] cfg_duty,
  output logic          tick_o,
  output logic [N-1:0]  drv_val,
  output logic [N-1:0]  drv_mask
);
  localparam int unsigned DIV = CLK_HZ / TICK_HZ;

  logic          take;
  logic          kill;
  logic [PW-1:0] thr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_ready <= 1'b0;
    else        cfg_ready <= 1'b1;
  end

  // A request is only applied when every addressed pin is an output.
  assign take = cfg_valid && cfg_ready && ((cfg_mask & ~pin_is_out) == '0);
  assign kill = cfg_stop || (cfg_period == '0);

  blink_tick #(.DIV(DIV)) tick_i (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_o)
  );

  blink_thresh #(.PW(PW), .DW(DW)) thr_i (
    .period (cfg_period),
    .duty   (cfg_duty),
    .thr    (thr)
  );

  for (genvar g = 0; g < N; g++) begin : g_ch
    ch_op_e op;
    always_comb begin
      op = CH_HOLD;
      if (take && cfg_mask[g]) op = kill ? CH_CLR : CH_LOAD;
    end
    blink_chan #(.PW(PW)) ch_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick_o),
      .op        (op),
      .period_in (cfg_period),
      .thr_in    (thr),
      .val       (drv_val[g]),
      .own       (drv_mask[g])
    );
  end
endmodule

// File: rtl/blink_engine_chk.sv
module blink_engine_chk #(
  parameter int unsigned N  = 20,
  parameter int unsigned PW = 16,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  pin_is_out,
  input logic          cfg_valid,
  input logic          cfg_ready,
  input logic [N-1:0]  cfg_mask,
  input logic          cfg_stop,
  input logic [PW-1:0] cfg_period,
  input logic [DW-1:0] cfg_duty,
  input logic          tick_o,
  input logic [N-1:0]  drv_val,
  input logic [N-1:0]  drv_mask
);
  logic acc, ok;
  assign acc = cfg_valid && cfg_ready;
  assign ok  = (cfg_mask & ~pin_is_out) == '0;

  a_r1_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

  a_r4_full_duty: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ok && !cfg_stop && cfg_period != '0 && cfg_duty >= DW'(100))
    |=> ((drv_val & $past(cfg_mask)) == $past(cfg_mask)));

  a_r6_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ok && (cfg_stop || cfg_period == '0))
    |=> ((drv_val & $past(cfg_mask)) == '0));

  a_r7_reject_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !ok) |=> $stable(drv_mask));

  a_r8_val_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_val & ~drv_mask) == '0);

  a_r8_mask_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(drv_mask) & ~drv_mask) == '0);
endmodule

bind blink_engine blink_engine_chk #(.N(N), .PW(PW), .DW(DW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .pin_is_out (pin_is_out),
  .cfg_valid  (cfg_valid),
  .cfg_ready  (cfg_ready),
  .cfg_mask   (cfg_mask),
  .cfg_stop   (cfg_stop),
  .cfg_period (cfg_period),
  .cfg_duty   (cfg_duty),
  .tick_o     (tick_o),
  .drv_val    (drv_val),
  .drv_mask   (drv_mask)
);

// File: tb/blink_engine_tb.sv
module blink_engine_tb_top;
  localparam int N = 20, PW = 16, DW = 8;
  localparam int CLK_HZ = 1000, TICK_HZ = 100, DIV = CLK_HZ / TICK_HZ;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] pin_is_out = '1, cfg_mask = '0;
  logic cfg_valid = 1'b0, cfg_stop = 1'b0;
  logic [PW-1:0] cfg_period = '0;
  logic [DW-1:0] cfg_duty = '0;
  logic cfg_ready, tick_o;
  logic [N-1:0] drv_val, drv_mask;

  int checks = 0, failures = 0;
  int m_cnt[N], m_per[N], m_thr[N];
  logic [N-1:0] m_own = '0;
  int cyc_no = 0, last_tick = -1;
  bit done = 0;

  always #5 clk = ~clk;

  blink_engine #(.N(N), .PW(PW), .DW(DW), .CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_is_out(pin_is_out), .cfg_valid(cfg_valid),
    .cfg_ready(cfg_ready), .cfg_mask(cfg_mask), .cfg_stop(cfg_stop),
    .cfg_period(cfg_period), .cfg_duty(cfg_duty), .tick_o(tick_o),
    .drv_val(drv_val), .drv_mask(drv_mask));

  function automatic int exp_thr(int p, int d);
    int dc = (d > 100) ? 100 : d;
    return (p * dc) / 100;
  endfunction

  function automatic logic [N-1:0] exp_val();
    logic [N-1:0] v = '0;
    for (int i = 0; i < N; i++) v[i] = (m_per[i] != 0) && (m_cnt[i] < m_thr[i]);
    return v;
  endfunction

  task automatic check(bit cond, string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: update model at the edge, compare at the next falling edge.
  task automatic cyc(string tag);
    bit tk = tick_o;
    bit tk_ok = 1'b1;
    @(posedge clk);
    if (cfg_valid && cfg_ready && ((cfg_mask & ~pin_is_out) == '0)) begin
      for (int i = 0; i < N; i++) if (cfg_mask[i]) begin
        m_own[i] = 1'b1;
        m_cnt[i] = 0;
        if (cfg_stop || cfg_period == 0) begin m_per[i] = 0; m_thr[i] = 0; end
        else begin m_per[i] = cfg_period; m_thr[i] = exp_thr(cfg_period, cfg_duty); end
      end
      for (int i = 0; i < N; i++) if (!cfg_mask[i] && tk && m_per[i] != 0)
        m_cnt[i] = (m_cnt[i] + 1 >= m_per[i]) ? 0 : m_cnt[i] + 1;
    end else if (tk) begin
      for (int i = 0; i < N; i++) if (m_per[i] != 0)
        m_cnt[i] = (m_cnt[i] + 1 >= m_per[i]) ? 0 : m_cnt[i] + 1;
    end
    if (tk) begin
      if (last_tick >= 0 && cyc_no - last_tick != DIV) tk_ok = 1'b0;
      check(tk_ok, "R1 tick spacing", N'(cyc_no - last_tick), N'(DIV));
      last_tick = cyc_no;
    end
    cyc_no++;
    @(negedge clk);
    check(drv_val == exp_val(), {tag, " drv_val"}, drv_val, exp_val());
    check(drv_mask == m_own, {tag, " drv_mask R8"}, drv_mask, m_own);
  endtask

  task automatic send(logic [N-1:0] m, bit stp, int p, int d, string tag);
    cfg_valid = 1'b1; cfg_mask = m; cfg_stop = stp;
    cfg_period = PW'(p); cfg_duty = DW'(d);
    cyc(tag);
    cfg_valid = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin m_cnt[i] = 0; m_per[i] = 0; m_thr[i] = 0; end
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(drv_val == '0 && drv_mask == '0, "R8 reset state", drv_val | drv_mask, '0);
    rst_n = 1'b1;
    cyc("R9 idle");
    check(cfg_ready == 1'b1, "R9 ready after reset", N'(cfg_ready), N'(1));

    // R3/R5: P=4 D=50 -> on 2 of 4 ticks; R4: D=150 always on; D=0 always off
    send(20'h00001, 0, 4, 50, "R5 load ch0");
    send(20'h00002, 0, 3, 150, "R4 clamp ch1");
    send(20'h00004, 0, 5, 0, "R3 zero duty ch2");
    send(20'h00008, 0, 7, 33, "R3 ch3 floor 7*33/100=2");
    repeat (80) cyc("R2 R3 blink");

    // R7: pin 5 is not an output, request naming 5 and 3 is dropped
    pin_is_out = 20'hFFFDF;
    send(20'h00028, 1, 0, 0, "R7 rejected stop");
    repeat (15) cyc("R7 after reject");
    pin_is_out = '1;

    // R9: request in the same cycle as a tick
    while (tick_o !== 1'b1) cyc("R9 wait tick");
    send(20'h00001, 0, 6, 50, "R9 load on tick");
    repeat (30) cyc("R9 after collision");

    // R6: stop flag and zero period
    send(20'h00001, 1, 9, 50, "R6 stop ch0");
    send(20'h00002, 0, 0, 80, "R6 zero period ch1");
    repeat (25) cyc("R6 stopped stays low");

    // Random phase
    for (int k = 0; k < 1500; k++) begin
      if ($urandom_range(0, 9) < 4) begin
        pin_is_out = ($urandom_range(0, 19) == 0) ? N'($urandom) : '1;
        send(N'($urandom) & N'($urandom), $urandom_range(0, 9) == 0,
             $urandom_range(0, 12), $urandom_range(0, 120), "R2 R3 R5 R6 R7 random");
      end else cyc("R2 R3 random idle");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired R1 actual=%0d expected=0", cyc_no);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule